// File: doc/BRIEF.md
# Serial Audio Link Codec Frame Engine

This block sits at the codec end of a five-wire, bit-serial, time-division audio link. The controller supplies the bit clock, a frame marker and a serial stream of output frames. The block returns a serial stream of input frames. Each frame is 256 bits long, and frames repeat at 48 kHz. A frame opens with a 16-bit tag slot. Twelve 20-bit slots follow, each sent MSB first. A 1 in a tag bit marks the matching slot of the same frame as valid.

On the receive side the block turns the serial stream back into slots. It decodes register commands from slots 1 and 2 and hands them to a register file as one-cycle write and read strobes. It also delivers the playback samples in slots 3 to 12 as parallel words, each with a strobe. On the transmit side it builds every input frame at the frame start. The frame carries the codec-ready flag first, then the slot tags, any pending read response and the capture samples. Any slot tagged invalid is sent as all zeros.

The block runs entirely on the bit clock, with a synchronous active-high reset. Serial inputs are sampled on the falling edge. Outputs change on the rising edge.

Top module: `aclink_codec_engine`

## Requirements
- R1: The first bit of each input frame (bit 15 of the tag slot) equals `codec_ready` as sampled at the frame start.
- R2: In the input tag slot, bit 12-j is 1 exactly when `cap_valid[j]` is 1 at the frame start. Slot j+3 then carries `cap_data[16j+15:16j]` in bits 19:4, with bits 3:0 zero.
- R3: Every input slot that is tagged invalid is all zeros, and `sdata_in` is 0 outside a frame.
- R4: When output slot k (3 to 12) is tagged valid (tag bit 15-k), `play_stb[k-3]` pulses for one cycle and `play_data` lane k-3 takes bits 19:4 of the slot. An untagged playback slot gives no pulse. No two lanes pulse in the same cycle.
- R5: `reg_wr` pulses only when tag bits 14 and 13 are both set, slot 1 bit 19 (the read flag) is 0 and `codec_ready` is 1. `reg_addr` then takes slot 1 bits 18:12 and `reg_wdata` takes slot 2 bits 19:4.
- R6: A slot 1 tagged valid with bit 19 set raises `reg_rd` with `reg_addr` from bits 18:12. `reg_rdata` must hold the read value in the cycle after `reg_rd`.
- R7: A read response is sent exactly once, in the next input frame that starts after the data is captured. That frame has tag bits 14 and 13 set, slot 1 bits 18:12 holding the address and slot 2 bits 19:4 holding the data.
- R8: While `codec_ready` is 0, register commands produce no `reg_wr` and no `reg_rd`.
- R9: A rising edge of `sync` starts a new frame, even in the middle of a frame, and the following slots are decoded from that point.
- R10: If the read data is captured in the same cycle that a new frame starts, the response is kept and sent in the frame after that one.
- R11: After reset, `sdata_in`, `reg_wr`, `reg_rd` and `play_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the controller |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame marker; a rising edge starts a frame |
| sdata_out | input | 1 | Serial output frames from the controller |
| sdata_in | output | 1 | Serial input frames to the controller |
| codec_ready | input | 1 | Codec ready; gates register traffic |
| cap_data | input | 160 | Capture samples, lane j for slot j+3 |
| cap_valid | input | 10 | Capture lane valid, sampled at frame start |
| play_data | output | 160 | Playback samples, lane j from slot j+3 |
| play_stb | output | 10 | One-cycle strobe per playback lane |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Read data, valid the cycle after reg_rd |

## Verification
Two events can land in the same cycle: capturing a read response and starting a new input frame, which takes a snapshot of the frame and clears the pending response. The bench provokes this by cutting off a read-carrying frame after 37 bits and starting the next frame at once. The frame that starts in the collision cycle must carry no response. The response must then appear in the frame after it. The cut-off frame is followed directly by a write, which must still decode correctly after the resynchronisation.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int DATA_SLOTS = 12;
  localparam int PCM_BITS   = 16;
  localparam int ADDR_BITS  = 7;
  localparam int FIRST_PCM  = 3;

  function automatic int tag_pos(input int slot_no, input int tag_w);
    return tag_w - 1 - slot_no;
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int TAG_W     = aclink_pkg::TAG_BITS,
  parameter int SLOT_W    = aclink_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_pkg::DATA_SLOTS
) (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  input  logic sdo,
  output logic start,
  output logic bit_vld,
  output logic slot_last,
  output logic [$clog2(NUM_SLOTS+1)-1:0] slot,
  output logic data_bit
);
  localparam int SIW = $clog2(NUM_SLOTS + 1);
  localparam int BW  = $clog2(SLOT_W);

  logic sync_n, sdo_n, sync_q, active;
  logic [SIW-1:0] slot_q, cur_slot;
  logic [BW-1:0]  bis_q, cur_bis;
  logic q_last, cur_last;

  // falling-edge capture of the serial inputs
  always_ff @(negedge clk) begin
    if (rst) begin
      sync_n <= 1'b0;
      sdo_n  <= 1'b0;
    end else begin
      sync_n <= sync;
      sdo_n  <= sdo;
    end
  end

  always_comb begin
    start    = sync_n & ~sync_q;
    q_last   = (slot_q == '0) ? (bis_q == BW'(TAG_W - 1)) : (bis_q == BW'(SLOT_W - 1));
    cur_slot = slot_q;
    cur_bis  = bis_q;
    bit_vld  = 1'b0;
    if (start) begin
      cur_slot = '0;
      cur_bis  = '0;
      bit_vld  = 1'b1;
    end else if (active) begin
      bit_vld = 1'b1;
      if (q_last) begin
        cur_slot = slot_q + SIW'(1);
        cur_bis  = '0;
      end else begin
        cur_bis = bis_q + BW'(1);
      end
    end
    cur_last = (cur_slot == '0) ? (cur_bis == BW'(TAG_W - 1)) : (cur_bis == BW'(SLOT_W - 1));
  end

  assign slot      = cur_slot;
  assign slot_last = cur_last;
  assign data_bit  = sdo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      active <= 1'b0;
      slot_q <= '0;
      bis_q  <= '0;
    end else begin
      sync_q <= sync_n;
      active <= bit_vld && !(cur_last && cur_slot == SIW'(NUM_SLOTS));
      if (bit_vld) begin
        slot_q <= cur_slot;
        bis_q  <= cur_bis;
      end
    end
  end

  AST_ACTIVE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> active);  // R9
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= SIW'(NUM_SLOTS));  // R9
endmodule

// File: rtl/aclink_rx_decode.sv
module aclink_rx_decode #(
  parameter int TAG_W     = aclink_pkg::TAG_BITS,
  parameter int SLOT_W    = aclink_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_pkg::DATA_SLOTS,
  parameter int SAMPLE_W  = aclink_pkg::PCM_BITS,
  parameter int ADDR_W    = aclink_pkg::ADDR_BITS,
  parameter int DATA_W    = aclink_pkg::PCM_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic slot_last,
  input  logic [$clog2(NUM_SLOTS+1)-1:0] slot,
  input  logic data_bit,
  input  logic codec_ready,
  output logic reg_wr,
  output logic reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [NUM_SLOTS-3:0] play_stb,
  output logic [(NUM_SLOTS-2)*SAMPLE_W-1:0] play_data
);
  localparam int SIW  = $clog2(NUM_SLOTS + 1);
  localparam int NPCM = NUM_SLOTS - 2;
  localparam int RD_BIT   = SLOT_W - 1;
  localparam int TAG_CMD  = aclink_pkg::tag_pos(1, TAG_W);
  localparam int TAG_WDAT = aclink_pkg::tag_pos(2, TAG_W);

  logic [SLOT_W-1:0] sh, word, cmd_q;
  logic [TAG_W-1:0]  tag_q;
  logic done;

  assign word = {sh[SLOT_W-2:0], data_bit};
  assign done = bit_vld && slot_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      cmd_q     <= '0;
      tag_q     <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (bit_vld) sh <= word;
      if (done && slot == '0) tag_q <= word[TAG_W-1:0];
      if (done && slot == SIW'(1)) begin
        cmd_q <= word;
        if (tag_q[TAG_CMD] && codec_ready && word[RD_BIT]) begin
          reg_rd   <= 1'b1;
          reg_addr <= word[RD_BIT-1 -: ADDR_W];
        end
      end
      if (done && slot == SIW'(2) && tag_q[TAG_CMD] && tag_q[TAG_WDAT]
          && codec_ready && !cmd_q[RD_BIT]) begin
        reg_wr    <= 1'b1;
        reg_addr  <= cmd_q[RD_BIT-1 -: ADDR_W];
        reg_wdata <= word[SLOT_W-1 -: DATA_W];
      end
    end
  end

  for (genvar j = 0; j < NPCM; j++) begin : g_play
    logic stb_r;
    logic [SAMPLE_W-1:0] dat_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        stb_r <= 1'b0;
        dat_r <= '0;
      end else if (done && slot == SIW'(j + aclink_pkg::FIRST_PCM)
                   && tag_q[aclink_pkg::tag_pos(j + aclink_pkg::FIRST_PCM, TAG_W)]) begin
        stb_r <= 1'b1;
        dat_r <= word[SLOT_W-1 -: SAMPLE_W];
      end else begin
        stb_r <= 1'b0;
      end
    end
    assign play_stb[j] = stb_r;
    assign play_data[j*SAMPLE_W +: SAMPLE_W] = dat_r;
  end

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));  // R5
  AST_WR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> $past(codec_ready));  // R8
  AST_RD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> $past(codec_ready));  // R8
endmodule

// File: rtl/aclink_tx_frame.sv
module aclink_tx_frame #(
  parameter int TAG_W     = aclink_pkg::TAG_BITS,
  parameter int SLOT_W    = aclink_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_pkg::DATA_SLOTS,
  parameter int SAMPLE_W  = aclink_pkg::PCM_BITS,
  parameter int ADDR_W    = aclink_pkg::ADDR_BITS,
  parameter int DATA_W    = aclink_pkg::PCM_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bit_vld,
  input  logic codec_ready,
  input  logic [(NUM_SLOTS-2)*SAMPLE_W-1:0] cap_data,
  input  logic [NUM_SLOTS-3:0] cap_valid,
  input  logic rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic sdata_in
);
  localparam int NPCM    = NUM_SLOTS - 2;
  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int BODY_HI = FRAME_W - TAG_W - 1;

  logic rd_q, pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [FRAME_W-1:0] frame_v, sh;
  logic [TAG_W-1:0] tag_w;

  // read response holding register; a capture outranks the frame-start clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      rd_q <= rd_fire;
      if (rd_q) begin
        pend      <= 1'b1;
        pend_addr <= rd_addr;
        pend_data <= rd_data;
      end else if (start) begin
        pend <= 1'b0;
      end
    end
  end

  always_comb begin
    tag_w = '0;
    tag_w[TAG_W-1] = codec_ready;
    tag_w[aclink_pkg::tag_pos(1, TAG_W)] = pend;
    tag_w[aclink_pkg::tag_pos(2, TAG_W)] = pend;
    for (int j = 0; j < NPCM; j++)
      tag_w[aclink_pkg::tag_pos(j + aclink_pkg::FIRST_PCM, TAG_W)] = cap_valid[j];
    frame_v = '0;
    frame_v[FRAME_W-1 -: TAG_W] = tag_w;
    if (pend) begin
      frame_v[BODY_HI -: SLOT_W] = {1'b0, pend_addr, {(SLOT_W-1-ADDR_W){1'b0}}};
      frame_v[BODY_HI-SLOT_W -: SLOT_W] = {pend_data, {(SLOT_W-DATA_W){1'b0}}};
    end
    for (int j = 0; j < NPCM; j++)
      if (cap_valid[j])
        frame_v[BODY_HI-(j+2)*SLOT_W -: SLOT_W] =
          {cap_data[j*SAMPLE_W +: SAMPLE_W], {(SLOT_W-SAMPLE_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      sdata_in <= 1'b0;
    end else if (start) begin
      sdata_in <= frame_v[FRAME_W-1];
      sh       <= {frame_v[FRAME_W-2:0], 1'b0};
    end else if (bit_vld) begin
      sdata_in <= sh[FRAME_W-1];
      sh       <= {sh[FRAME_W-2:0], 1'b0};
    end else begin
      sdata_in <= 1'b0;
    end
  end

  AST_READY_LEADS: assert property (@(posedge clk) disable iff (rst)
    start |=> (sdata_in == $past(codec_ready)));  // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> !sdata_in);  // R3
endmodule

// File: rtl/aclink_codec_engine.sv
module aclink_codec_engine #(
  parameter int TAG_W     = aclink_pkg::TAG_BITS,
  parameter int SLOT_W    = aclink_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_pkg::DATA_SLOTS,
  parameter int SAMPLE_W  = aclink_pkg::PCM_BITS,
  parameter int ADDR_W    = aclink_pkg::ADDR_BITS,
  parameter int DATA_W    = aclink_pkg::PCM_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  input  logic sdata_out,
  output logic sdata_in,
  input  logic codec_ready,
  input  logic [(NUM_SLOTS-2)*SAMPLE_W-1:0] cap_data,
  input  logic [NUM_SLOTS-3:0] cap_valid,
  output logic [(NUM_SLOTS-2)*SAMPLE_W-1:0] play_data,
  output logic [NUM_SLOTS-3:0] play_stb,
  output logic reg_wr,
  output logic reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int SIW = $clog2(NUM_SLOTS + 1);

  logic start, bit_vld, slot_last, data_bit;
  logic [SIW-1:0] slot;

  aclink_frame_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk(clk), .rst(rst), .sync(sync), .sdo(sdata_out), .start(start),
    .bit_vld(bit_vld), .slot_last(slot_last), .slot(slot), .data_bit(data_bit));

  aclink_rx_decode #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .slot_last(slot_last), .slot(slot),
    .data_bit(data_bit), .codec_ready(codec_ready), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .play_stb(play_stb), .play_data(play_data));

  aclink_tx_frame #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .start(start), .bit_vld(bit_vld), .codec_ready(codec_ready),
    .cap_data(cap_data), .cap_valid(cap_valid), .rd_fire(reg_rd), .rd_addr(reg_addr),
    .rd_data(reg_rdata), .sdata_in(sdata_in));

  AST_PLAY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(play_stb));  // R4
endmodule

// File: tb/sim_aclink_codec_engine.sv
module sim_aclink_codec_engine;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, sync = 1'b0, sdata_out = 1'b0, codec_ready = 1'b1;
  logic sdata_in, reg_wr, reg_rd;
  logic [159:0] cap_data = '0, play_data;
  logic [9:0] cap_valid = '0, play_stb;
  logic [6:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int tests = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic [6:0] last_waddr, last_raddr;
  logic [15:0] last_wdata;
  logic [9:0] seen;
  logic [15:0] pdat [10];
  logic [15:0] o_tag;
  logic [19:0] o_slot [1:12];
  logic [255:0] got;
  bit done = 0;

  // rows: {playback tags for slots 3..12, capture valid, seed}
  localparam logic [27:0] VEC [5] = '{
    {10'h3FF, 10'h3FF, 8'h11}, {10'h000, 10'h000, 8'h22}, {10'h155, 10'h2AA, 8'h5A},
    {10'h001, 10'h200, 8'hC3}, {10'h2AA, 10'h0F0, 8'h07}};

  always #(PERIOD/2) clk = ~clk;

  aclink_codec_engine u0 (.clk(clk), .rst(rst), .sync(sync), .sdata_out(sdata_out),
    .sdata_in(sdata_in), .codec_ready(codec_ready), .cap_data(cap_data), .cap_valid(cap_valid),
    .play_data(play_data), .play_stb(play_stb), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // register file model: data valid the cycle after the read strobe
  always @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= {reg_addr, 9'h1A5};
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr) begin wr_cnt++; last_waddr = reg_addr; last_wdata = reg_wdata; end
      if (reg_rd) begin rd_cnt++; last_raddr = reg_addr; end
      for (int j = 0; j < 10; j++)
        if (play_stb[j]) begin seen[j] = 1'b1; pdat[j] = play_data[16*j +: 16]; end
    end
  end

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_in(input logic rdy, input logic rv, input logic [6:0] ra,
      input logic [15:0] rdat, input logic [9:0] cv, input logic [159:0] cd);
    logic [255:0] v = '0;
    v[255] = rdy; v[254] = rv; v[253] = rv;
    for (int j = 0; j < 10; j++) v[252-j] = cv[j];
    if (rv) begin
      v[239:220] = {1'b0, ra, 12'h000};
      v[219:200] = {rdat, 4'h0};
    end
    for (int j = 0; j < 10; j++) if (cv[j]) v[199-20*j -: 20] = {cd[16*j +: 16], 4'h0};
    return v;
  endfunction

  task automatic clear_out();
    o_tag = '0;
    for (int k = 1; k <= 12; k++) o_slot[k] = '0;
  endtask

  task automatic run_frame(input int nbits, input bit tail);
    logic [255:0] v;
    v[255:240] = o_tag;
    for (int k = 1; k <= 12; k++) v[239-20*(k-1) -: 20] = o_slot[k];
    got = '0;
    for (int i = 0; i < nbits + (tail ? 1 : 0); i++) begin
      @(posedge clk); #1;
      sync = (i < nbits) && (i < 16);
      sdata_out = (i < nbits) ? v[255-i] : 1'b0;
      @(negedge clk); #1;
      if (i >= 1 && i <= 256) got[256-i] = sdata_in;
    end
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    check("R11 reset outputs", {232'b0, sdata_in, reg_wr, reg_rd, play_stb}, '0);
    rst = 1'b0;
    repeat (3) @(posedge clk);

    // table of playback/capture patterns
    for (int r = 0; r < 5; r++) begin
      logic [9:0] pt, cv;
      logic [7:0] seed;
      pt = VEC[r][27:18]; cv = VEC[r][17:8]; seed = VEC[r][7:0];
      clear_out();
      for (int j = 0; j < 10; j++) begin
        o_tag[12-j] = pt[j];
        o_slot[j+3] = {seed, 8'(j*17+1), 4'h5};
        cap_data[16*j +: 16] = {8'(j*29+3), seed ^ 8'hA5};
      end
      cap_valid = cv;
      seen = '0;
      run_frame(256, 1);
      check("R4 playback strobes", {246'b0, seen}, {246'b0, pt});
      for (int j = 0; j < 10; j++)
        if (pt[j]) check("R4 playback data", {240'b0, pdat[j]}, {240'b0, seed, 8'(j*17+1)});
      check("R2 capture tags", {240'b0, got[255:240]}, {240'b0, exp_in(1, 0, 0, 0, cv, cap_data) >> 240});
      check("R3 R1 full input frame", got, exp_in(1, 0, 0, 0, cv, cap_data));
      repeat (3) @(posedge clk);
    end
    cap_valid = '0;

    // valid write
    w0 = wr_cnt;
    clear_out(); o_tag[14] = 1; o_tag[13] = 1;
    o_slot[1] = {1'b0, 7'h15, 12'h0}; o_slot[2] = {16'hBEEF, 4'h0};
    run_frame(256, 1);
    check("R5 write count", 256'(wr_cnt - w0), 256'd1);
    check("R5 write addr/data", {233'b0, last_waddr, last_wdata}, {233'b0, 7'h15, 16'hBEEF});
    check("R7 no response without read", got, exp_in(1, 0, 0, 0, 0, 0));

    // write with data slot untagged
    w0 = wr_cnt;
    o_tag[13] = 0; o_slot[2] = {16'h1111, 4'h0};
    run_frame(256, 1);
    check("R5 untagged data slot ignored", 256'(wr_cnt - w0), 256'd0);

    // not ready: write and read both ignored
    codec_ready = 0;
    w0 = wr_cnt; r0 = rd_cnt;
    o_tag[13] = 1;
    run_frame(256, 1);
    check("R8 write ignored while not ready", 256'(wr_cnt - w0), 256'd0);
    check("R1 ready bit low", {255'b0, got[255]}, 256'd0);
    clear_out(); o_tag[14] = 1; o_slot[1] = {1'b1, 7'h26, 12'h0};
    run_frame(256, 1);
    check("R8 read ignored while not ready", 256'(rd_cnt - r0), 256'd0);
    codec_ready = 1;

    // read and its response
    r0 = rd_cnt;
    run_frame(256, 1);
    check("R6 read count", 256'(rd_cnt - r0), 256'd1);
    check("R6 read addr", {249'b0, last_raddr}, {249'b0, 7'h26});
    clear_out();
    run_frame(256, 1);
    check("R7 read response", got, exp_in(1, 1, 7'h26, {7'h26, 9'h1A5}, 0, 0));
    run_frame(256, 1);
    check("R7 response sent once", got, exp_in(1, 0, 0, 0, 0, 0));

    // collision: truncated read frame, new frame starts in the capture cycle
    r0 = rd_cnt; w0 = wr_cnt;
    clear_out(); o_tag[14] = 1; o_slot[1] = {1'b1, 7'h0B, 12'h0};
    run_frame(37, 0);
    clear_out(); o_tag[14] = 1; o_tag[13] = 1;
    o_slot[1] = {1'b0, 7'h30, 12'h0}; o_slot[2] = {16'h1234, 4'h0};
    run_frame(256, 1);
    check("R6 read in truncated frame", 256'(rd_cnt - r0), 256'd1);
    check("R10 colliding frame holds no response", got, exp_in(1, 0, 0, 0, 0, 0));
    check("R9 write after resync", {232'b0, 8'(wr_cnt - w0), last_waddr, last_wdata[8:0]},
          {232'b0, 8'd1, 7'h30, 9'h034});
    check("R9 write data after resync", {240'b0, last_wdata}, {240'b0, 16'h1234});
    clear_out();
    run_frame(256, 1);
    check("R10 deferred response", got, exp_in(1, 1, 7'h0B, {7'h0B, 9'h1A5}, 0, 0));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule